// File: doc/BRIEF.md
# Eight-Channel Serially Addressed Trim Code Bank

This block is the digital core of an eight-channel trim converter. A host writes one channel at a time over a three-wire serial link: it pulls the select line low and clocks bits in on the data line. When the select line returns high, the block takes the last eleven bits it received. The upper three bits of that word pick a channel, and the lower eight bits become that channel's code. The eight codes come out side by side on one flat bus, and the analog ladder downstream reads them from there.

The serial clock, select and data pins are brought into a faster system clock through synchronizers. All edge detection, shifting and committing happen in the system clock domain. An active-low preset pin forces every code to midscale at once, and the block leaves preset only on a system clock edge. An active-low sleep pin lowers an output-enable flag and leaves every stored code unchanged. A status output counts the bits received in the current frame.

Top module: `trim_bank_core`

## Requirements
- R1: After system reset every channel code is 0x80 and the bit counter reads 0. Once the sleep pin has been synchronized high, the output-enable flag reads 1.
- R2: A frame consists of the select pin low, then bits shifted on rising serial-clock edges, then the select pin high. Each frame is 11 bits: a 3-bit channel address first, MSB first, then 8 code bits, MSB first. When select rises, channel a receives the code. Channel a occupies bits [8a+7:8a] of `chan_codes`.
- R3: A frame changes only the addressed channel. All other channels keep their codes, and no two channels change in the same system cycle.
- R4: When a frame carries more than 11 bits, only the last 11 bits count. The earlier bits are dropped.
- R5: When a frame carries fewer than 11 bits, the commit still uses the whole 11-bit shift register. The new bits sit at the low end, below the bits left over from earlier frames.
- R6: While select is high, serial-clock edges shift nothing into the register.
- R7: The bit counter clears to 0 when select falls. It then counts each shifted bit and stops at 11.
- R8: Preset low drives all eight codes to 0x80 without waiting for a system clock edge. The codes stay at 0x80 while preset stays low.
- R9: When a commit falls while preset is active, preset wins and every code stays 0x80.
- R10: Sleep low drives the output-enable flag to 0 within two system cycles and leaves all codes unchanged. Frames received while asleep still load their channels. When sleep is released, the flag returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| ser_clk | input | 1 | Serial clock; bits are shifted on its rising edge |
| ser_cs_n | input | 1 | Active-low frame select; its rising edge commits the word |
| ser_din | input | 1 | Serial data, MSB first |
| preset_n | input | 1 | Asynchronous active-low preset of all codes to midscale |
| sleep_n | input | 1 | Active-low shutdown request |
| chan_codes | output | 64 | Eight 8-bit channel codes, channel 0 in the low byte |
| out_en | output | 1 | Output enable, low while asleep |
| bit_count | output | 4 | Bits received in the current frame, saturating at 11 |

## Verification
The case that needs the most care is a frame commit that falls in the same cycle as a preset. The bench raises the select pin and drops preset on the same system clock edge, holds preset for several cycles, and then expects every channel to read 0x80 while the bit counter keeps its value. A second overlap comes from sending a full frame while sleep is held low. There the bench expects the addressed code to change while the enable flag stays low, and expects the flag to return to 1 when sleep is released with the new code still in place.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int unsigned DEF_NUM_CH      = 8;
  localparam int unsigned DEF_CODE_W      = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [63:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_nxt;

  always_comb begin
    stage_nxt[0] = d;
    for (int i = 1; i < STAGES; i++) stage_nxt[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL[WIDTH-1:0];
    end else begin
      stage_q <= stage_nxt;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/trim_shifter.sv
module trim_shifter #(
  parameter int unsigned WORD_W = 11,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(WORD_W);

  logic [WORD_W-1:0] word_nxt;
  logic [CNT_W-1:0]  count_base;
  logic [CNT_W-1:0]  count_nxt;

  always_comb begin
    word_nxt   = shift_en ? {word[WORD_W-2:0], din} : word;
    count_base = frame_start ? '0 : count;
    if (shift_en && count_base != SAT) count_nxt = count_base + 1'b1;
    else                               count_nxt = count_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      count <= '0;
    end else begin
      word  <= word_nxt;
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/trim_regfile.sv
module trim_regfile #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     clr_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_data,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_nxt;
    logic              hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(ch));

    always_comb begin
      code_nxt = hit ? wr_data : code_q;
    end

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) code_q <= MID;
      else        code_q <= code_nxt;
    end

    assign codes[ch*CODE_W +: CODE_W] = code_q;
  end
endmodule

// File: rtl/trim_bank_core.sv
module trim_bank_core #(
  parameter int unsigned NUM_CH      = trim_pkg::DEF_NUM_CH,
  parameter int unsigned CODE_W      = trim_pkg::DEF_CODE_W,
  parameter int unsigned SYNC_STAGES = trim_pkg::DEF_SYNC_STAGES
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   ser_clk,
  input  logic                                   ser_cs_n,
  input  logic                                   ser_din,
  input  logic                                   preset_n,
  input  logic                                   sleep_n,
  output logic [NUM_CH*CODE_W-1:0]               chan_codes,
  output logic                                   out_en,
  output logic [$clog2(CODE_W+$clog2(NUM_CH)+1)-1:0] bit_count
);
  localparam int unsigned ADDR_W = $clog2(NUM_CH);
  localparam int unsigned WORD_W = ADDR_W + CODE_W;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  logic rst_q_n;
  logic clr_raw_n;
  logic clr_q_n;

  trim_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(64'd0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q_n)
  );

  assign clr_raw_n = rst_n & preset_n;

  trim_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(64'd0)) u_clr_sync (
    .clk(clk), .rst_n(clr_raw_n), .d(1'b1), .q(clr_q_n)
  );

  logic [3:0] pins_s;
  logic       s_clk, s_cs_n, s_din, s_sleep_n;

  trim_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(64'hC)) u_pin_sync (
    .clk(clk), .rst_n(rst_q_n),
    .d({ser_clk, ser_cs_n, ser_din, sleep_n}),
    .q(pins_s)
  );

  assign {s_clk, s_cs_n, s_din, s_sleep_n} = pins_s;

  logic prev_clk, prev_cs_n;
  logic prev_clk_nxt, prev_cs_n_nxt;
  logic shift_en, frame_start, commit;

  always_comb begin
    prev_clk_nxt  = s_clk;
    prev_cs_n_nxt = s_cs_n;
    shift_en      = s_clk & ~prev_clk & ~s_cs_n;
    frame_start   = ~s_cs_n & prev_cs_n;
    commit        = s_cs_n & ~prev_cs_n;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      prev_clk  <= 1'b1;
      prev_cs_n <= 1'b1;
    end else begin
      prev_clk  <= prev_clk_nxt;
      prev_cs_n <= prev_cs_n_nxt;
    end
  end

  logic [WORD_W-1:0] word;

  trim_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shifter (
    .clk(clk), .rst_n(rst_q_n),
    .frame_start(frame_start), .shift_en(shift_en), .din(s_din),
    .word(word), .count(bit_count)
  );

  trim_regfile #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .clr_n(clr_q_n),
    .wr_en(commit),
    .wr_addr(word[WORD_W-1 -: ADDR_W]),
    .wr_data(word[CODE_W-1:0]),
    .codes(chan_codes)
  );

  assign out_en = s_sleep_n;
endmodule

// File: rtl/trim_bank_chk.sv
module trim_bank_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     preset_n,
  input logic                     sleep_n,
  input logic [NUM_CH*CODE_W-1:0] chan_codes,
  input logic                     out_en,
  input logic [CNT_W-1:0]         bit_count
);
  localparam int unsigned WORD_W = $clog2(NUM_CH) + CODE_W;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [NUM_CH*CODE_W-1:0] prev_codes;
  logic                     prev_ok;
  logic [NUM_CH-1:0]        moved;
  logic [NUM_CH*CODE_W-1:0] all_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_codes <= '0;
      prev_ok    <= 1'b0;
    end else begin
      prev_codes <= chan_codes;
      prev_ok    <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      moved[i] = chan_codes[i*CODE_W +: CODE_W] != prev_codes[i*CODE_W +: CODE_W];
      all_mid[i*CODE_W +: CODE_W] = MID;
    end
  end

  assert_one_channel_R3: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
    prev_ok |-> ($countones(moved) <= 1));

  assert_count_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= CNT_W'(WORD_W));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_count != $past(bit_count)) |->
      (bit_count == $past(bit_count) + 1'b1) || (bit_count <= CNT_W'(1)));

  assert_preset_mid_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |-> (chan_codes == all_mid));

  assert_sleep_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sleep_n) && !$past(sleep_n, 2)) |-> !out_en);
endmodule

bind trim_bank_core trim_bank_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .CNT_W($clog2(CODE_W + $clog2(NUM_CH) + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .sleep_n(sleep_n),
  .chan_codes(chan_codes), .out_en(out_en), .bit_count(bit_count)
);

// File: tb/trim_bank_core_tb.sv
module trim_bank_core_tb;
  logic        clk = 1'b0;
  logic        rst_n, ser_clk, ser_cs_n, ser_din, preset_n, sleep_n;
  logic [63:0] chan_codes;
  logic        out_en;
  logic [3:0]  bit_count;

  always #4 clk = ~clk;

  trim_bank_core u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
    .ser_din(ser_din), .preset_n(preset_n), .sleep_n(sleep_n),
    .chan_codes(chan_codes), .out_en(out_en), .bit_count(bit_count)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  logic [7:0]  m_codes [8];
  logic [10:0] m_sr;
  logic [3:0]  m_cnt;
  logic        m_oe;

  function automatic logic [63:0] pack_model();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_codes[i];
    return v;
  endfunction

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    cmp(req, "codes", chan_codes, pack_model());
    cmp(req, "count", 64'(bit_count), 64'(m_cnt));
    cmp(req, "out_en", 64'(out_en), 64'(m_oe));
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bits(input int n, input logic [31:0] pat);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = pat[i];
      ser_clk = 1'b0;
      wait_n(3);
      ser_clk = 1'b1;
      wait_n(3);
      if (!ser_cs_n) begin
        m_sr = {m_sr[9:0], pat[i]};
        if (m_cnt < 4'd11) m_cnt = m_cnt + 4'd1;
      end
    end
  endtask

  task automatic frame(input int n, input logic [31:0] pat);
    ser_cs_n = 1'b0;
    m_cnt    = 4'd0;
    wait_n(3);
    drive_bits(n, pat);
    ser_cs_n = 1'b1;
    m_codes[m_sr[10:8]] = m_sr[7:0];
    wait_n(10);
  endtask

  task automatic all_mid();
    for (int i = 0; i < 8; i++) m_codes[i] = 8'h80;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; ser_clk = 1'b1; ser_cs_n = 1'b1; ser_din = 1'b0;
    preset_n = 1'b1; sleep_n = 1'b1;
    all_mid(); m_sr = '0; m_cnt = '0; m_oe = 1'b1;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(8);
    check_state("R1");

    // R2: channel 0 and channel 7, address then code, MSB first
    frame(11, {21'd0, 3'd0, 8'h3C});
    check_state("R2");
    frame(11, {21'd0, 3'd7, 8'hE1});
    check_state("R2");

    // R4: 16-bit frame, leading 5 bits dropped
    frame(16, {16'd0, 5'b10110, 3'd3, 8'h5A});
    check_state("R4");

    // R5: short frame of 5 bits
    frame(5, {27'd0, 5'b10011});
    check_state("R5");

    // R6: serial clock toggled while select high shifts nothing
    drive_bits(6, 32'h2B);
    wait_n(5);
    check_state("R6");
    frame(3, 32'h5);
    check_state("R6");

    // R7: saturation at 11 and clear on select fall
    frame(14, {18'd0, 3'b111, 3'd2, 8'h99});
    check_state("R7");
    frame(0, 32'd0);
    check_state("R7");

    // R8: preset acts before any clock edge
    frame(11, {21'd0, 3'd5, 8'h11});
    #1 preset_n = 1'b0;
    #1;
    all_mid();
    cmp("R8", "async codes", chan_codes, pack_model());
    wait_n(4);
    check_state("R8");
    preset_n = 1'b1;
    wait_n(5);
    check_state("R8");

    // R9: commit and preset at once
    ser_cs_n = 1'b0; m_cnt = 4'd0;
    wait_n(3);
    drive_bits(11, {21'd0, 3'd4, 8'h42});
    ser_cs_n = 1'b1;
    preset_n = 1'b0;
    wait_n(10);
    preset_n = 1'b1;
    wait_n(5);
    all_mid();
    check_state("R9");

    // R10: sleep keeps codes, frames still load, flag returns
    frame(11, {21'd0, 3'd6, 8'hA7});
    sleep_n = 1'b0; m_oe = 1'b0;
    wait_n(4);
    check_state("R10");
    frame(11, {21'd0, 3'd1, 8'h0F});
    check_state("R10");
    sleep_n = 1'b1; m_oe = 1'b1;
    wait_n(4);
    check_state("R10");

    // R3: random frames, lengths 0..16, with idle clocking between
    for (int k = 0; k < 40; k++) begin
      int          n;
      logic [31:0] pat;
      n   = int'($urandom_range(0, 16));
      pat = $urandom;
      if ($urandom_range(0, 3) == 0) drive_bits(int'($urandom_range(1, 5)), $urandom);
      frame(n, pat);
      check_state("R3");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule